// File: doc/BRIEF.md
# Dual-Channel DAC Update Sequencer

This block is the host-side controller for a two-channel serial DAC. A one-cycle start strobe carries two 12-bit codes. The block then sends two framed 16-bit words over a three-wire serial link, one frame for each channel. It finishes with a separate active-low load pulse, so both analog outputs change at the same moment. The serial clock comes from the system clock through a programmable half-period divider. The data line changes on the rising serial-clock edge, so it is stable whenever the receiver samples on the falling edge.

Each word carries the channel-select bit at position 12, the code in bits 11..0, and zeros in bits 15..13. A byte-split option sends every word as two 8-bit bursts and keeps the frame line low across the pause between them. An automatic-update option holds the load line low all the time and sends no pulse, because the converter then updates at the end of each word. The gap between the two frames and the width of the load pulse are both programmable. Each lasts at least one serial-clock period.

Top module: `dac_pair_seq`

## Requirements
- R1: While reset is held and just after it, `sclk` is 0, `sync_n` is 1, `busy` is 0 and, with `auto_update` = 0, `ldac_n` is 1.
- R2: The first frame of a sequence has exactly 16 falling `sclk` edges while `sync_n` is low. Sampled MSB first at those edges, `sdin` gives `{3'b000, 1'b0, code_a}`. Falling `sclk` edges occur only while `sync_n` is low.
- R3: The second frame follows the first and carries `{3'b000, 1'b1, code_b}`, with bit 12 = 1 selecting channel B. Every sequence produces exactly two frames.
- R4: `sclk` is low whenever `sync_n` is high. `sdin` changes only in the cycle in which `sclk` rises.
- R5: The half-period of `sclk` is N = max(`half_div`, 1) system clocks. Consecutive falling edges inside one burst are 2N clocks apart.
- R6: Between the two frames, `sync_n` stays high for exactly max(`gap_clks`, 2N) clocks.
- R7: With `byte_mode` = 1, falling edges 8 and 9 of a frame are 4N clocks apart, and `sync_n` stays low across that pause.
- R8: With `auto_update` = 0, `ldac_n` falls only after the second frame has ended (`sync_n` high). It stays low for exactly max(`ldac_clks`, 2N) clocks. `busy` falls in the same cycle that `ldac_n` rises.
- R9: With `auto_update` = 1, `ldac_n` is held at 0 and no pulse is sent. `busy` falls in the same cycle that `sync_n` rises after the second frame.
- R10: A `start` that arrives while `busy` is high is ignored: no extra frame is sent and the codes in flight are not changed.
- R11: A `start` while idle makes `busy` go high and `sync_n` go low on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to run a two-channel update |
| code_a | input | 12 | Code for channel A, captured at start |
| code_b | input | 12 | Code for channel B, captured at start |
| half_div | input | 8 | Serial-clock half-period in system clocks (0 counts as 1) |
| gap_clks | input | 8 | Frame-line high time between the two frames (minimum 2N) |
| ldac_clks | input | 8 | Load-pulse low time (minimum 2N) |
| byte_mode | input | 1 | Send each word as two 8-bit bursts |
| auto_update | input | 1 | Hold the load line low and send no pulse |
| sclk | output | 1 | Serial clock, idles low |
| sdin | output | 1 | Serial data, MSB first |
| sync_n | output | 1 | Active-low frame line |
| ldac_n | output | 1 | Active-low load line |
| busy | output | 1 | High from start until the sequence ends |

## Verification
The sequencer is run with codes at the extremes and in the middle: 0x7FF/0x800, 0x001/0xFFF and mixed patterns. These show whether the bits are ordered and shifted correctly and whether the select bit lands on the right frame. The divider is tried at a half-period of 0, 1, 2 and 3, and the gap and pulse settings are tried both below and above the one-period minimum. Together these separate a timing error from the clamping rule. A byte-split run and an automatic-update run show whether the pause is placed inside the frame and whether the pulse is suppressed. A start issued in the middle of a sequence shows whether the in-flight codes stay protected.

// File: rtl/dac_seq_pkg.sv
`timescale 1ns/1ps
package dac_seq_pkg;
  parameter int CODE_W  = 12;
  parameter int WORD_W  = 16;
  parameter int SEL_BIT = 12;
  parameter int CFG_W   = 8;
  localparam int TMR_W  = CFG_W + 2;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int BYTE_W = WORD_W / 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SHIFT, ST_PAUSE, ST_TAIL, ST_GAP, ST_PULSE
  } seq_st_e;

  // half-period in system clocks, a zero setting counts as one
  function automatic logic [CFG_W-1:0] half_eff(input logic [CFG_W-1:0] h);
    return (h == '0) ? CFG_W'(1) : h;
  endfunction

  // one full serial-clock period
  function automatic logic [TMR_W-1:0] period_len(input logic [CFG_W-1:0] h);
    return TMR_W'(half_eff(h)) << 1;
  endfunction

  // programmable span clamped to at least one period
  function automatic logic [TMR_W-1:0] span_len(input logic [CFG_W-1:0] v,
                                                input logic [CFG_W-1:0] h);
    logic [TMR_W-1:0] p;
    p = period_len(h);
    return (TMR_W'(v) > p) ? TMR_W'(v) : p;
  endfunction

  function automatic logic [WORD_W-1:0] make_word(input logic sel,
                                                  input logic [CODE_W-1:0] code);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CODE_W-1:0] = code;
    w[SEL_BIT] = sel;
    return w;
  endfunction
endpackage

// File: rtl/sclk_gen.sv
`timescale 1ns/1ps
module sclk_gen
  import dac_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CFG_W-1:0] half,
  output logic             sclk,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [CFG_W-1:0] cnt;
  logic             edge_due;

  assign edge_due = run && (cnt == half_eff(half) - CFG_W'(1));
  assign rise_evt = edge_due && !sclk;
  assign fall_evt = edge_due && sclk;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (edge_due) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + CFG_W'(1);
    end
  end
endmodule

// File: rtl/frame_shift.sv
`timescale 1ns/1ps
module frame_shift
  import dac_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              rise_evt,
  output logic              sdin
);
  logic [WORD_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '0;
      sdin <= 1'b0;
    end else if (load) begin
      sreg <= word;
    end else if (rise_evt) begin
      sdin <= sreg[WORD_W-1];
      sreg <= {sreg[WORD_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/dac_pair_seq.sv
`timescale 1ns/1ps
module dac_pair_seq
  import dac_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  input  logic [CFG_W-1:0]  half_div,
  input  logic [CFG_W-1:0]  gap_clks,
  input  logic [CFG_W-1:0]  ldac_clks,
  input  logic              byte_mode,
  input  logic              auto_update,
  output logic              sclk,
  output logic              sdin,
  output logic              sync_n,
  output logic              ldac_n,
  output logic              busy
);
  seq_st_e           state;
  logic [TMR_W-1:0]  tmr;
  logic [BIT_W-1:0]  bit_cnt;
  logic              chan_b;
  logic [CODE_W-1:0] code_b_q;
  logic              sync_q, ldac_q, busy_q, run;
  logic              sclk_w, sdin_w, rise_evt, fall_evt;
  logic              load;
  logic [WORD_W-1:0] word;
  logic              tmr_done;

  assign tmr_done = (tmr == '0);
  assign load = (state == ST_IDLE && start) || (state == ST_GAP && tmr_done);
  assign word = (state == ST_IDLE) ? make_word(1'b0, code_a)
                                   : make_word(1'b1, code_b_q);

  sclk_gen u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .half(half_div),
    .sclk(sclk_w), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  frame_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .word(word),
    .rise_evt(rise_evt), .sdin(sdin_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tmr      <= '0;
      bit_cnt  <= '0;
      chan_b   <= 1'b0;
      code_b_q <= '0;
      sync_q   <= 1'b1;
      ldac_q   <= 1'b1;
      busy_q   <= 1'b0;
      run      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          code_b_q <= code_b;
          chan_b   <= 1'b0;
          bit_cnt  <= '0;
          sync_q   <= 1'b0;
          busy_q   <= 1'b1;
          run      <= 1'b1;
          state    <= ST_SHIFT;
        end
        ST_SHIFT: if (fall_evt) begin
          bit_cnt <= bit_cnt + BIT_W'(1);
          if (bit_cnt == BIT_W'(WORD_W-1)) begin
            run   <= 1'b0;
            tmr   <= TMR_W'(half_eff(half_div)) - TMR_W'(1);
            state <= ST_TAIL;
          end else if (byte_mode && bit_cnt == BIT_W'(BYTE_W-1)) begin
            run   <= 1'b0;
            tmr   <= period_len(half_div) - TMR_W'(1);
            state <= ST_PAUSE;
          end
        end
        ST_PAUSE: if (tmr_done) begin
          run   <= 1'b1;
          state <= ST_SHIFT;
        end else tmr <= tmr - TMR_W'(1);
        ST_TAIL: if (tmr_done) begin
          sync_q  <= 1'b1;
          bit_cnt <= '0;
          if (!chan_b) begin
            tmr   <= span_len(gap_clks, half_div) - TMR_W'(1);
            state <= ST_GAP;
          end else if (auto_update) begin
            busy_q <= 1'b0;
            state  <= ST_IDLE;
          end else begin
            ldac_q <= 1'b0;
            tmr    <= span_len(ldac_clks, half_div) - TMR_W'(1);
            state  <= ST_PULSE;
          end
        end else tmr <= tmr - TMR_W'(1);
        ST_GAP: if (tmr_done) begin
          sync_q <= 1'b0;
          chan_b <= 1'b1;
          run    <= 1'b1;
          state  <= ST_SHIFT;
        end else tmr <= tmr - TMR_W'(1);
        ST_PULSE: if (tmr_done) begin
          ldac_q <= 1'b1;
          busy_q <= 1'b0;
          state  <= ST_IDLE;
        end else tmr <= tmr - TMR_W'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sclk   = sclk_w;
  assign sdin   = sdin_w;
  assign sync_n = sync_q;
  assign ldac_n = ldac_q && !auto_update;
  assign busy   = busy_q;

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |-> !sclk_w);
  // R4
  sdin_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdin_w) |-> $rose(sclk_w));
  // R2
  fall_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |-> !sync_q);
  // R8
  ldac_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ldac_q |-> sync_q && !run);
  // R11
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy_q |=> busy_q && !sync_q);
endmodule

// File: tb/dac_pair_seq_tb.sv
`timescale 1ns/1ps
module dac_pair_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [11:0] code_a = '0, code_b = '0;
  logic [7:0] half_div = 8'd1, gap_clks = '0, ldac_clks = '0;
  logic byte_mode = 1'b0, auto_update = 1'b0;
  logic sclk, sdin, sync_n, ldac_n, busy;

  int checks = 0, errs = 0, cyc = 0;
  logic [15:0] exp_q[$];
  int exp_n = 1, exp_gap = 2, exp_ld = 2;
  bit cfg_byte = 0, cfg_auto = 0, in_seq = 0, mon_on = 0;
  int fr_idx = 0, frames_total = 0, nbits = 0;
  int last_fall = 0, sync_rise = 0, ldac_fall = 0;
  logic [15:0] acc = '0;
  logic p_sclk = 1'b0, p_sync = 1'b1, p_ldac = 1'b1;

  dac_pair_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .code_a(code_a), .code_b(code_b),
    .half_div(half_div), .gap_clks(gap_clks), .ldac_clks(ldac_clks),
    .byte_mode(byte_mode), .auto_update(auto_update),
    .sclk(sclk), .sdin(sdin), .sync_n(sync_n), .ldac_n(ldac_n), .busy(busy)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(0, "watchdog", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  // monitor: rebuilds frames from the pins and compares with the scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (p_sclk && !sclk && !sync_n) begin
        if (nbits > 0) begin
          if (cfg_byte && nbits == 8) chk(cyc - last_fall == 4*exp_n, "R7", cyc - last_fall, 4*exp_n);
          else chk(cyc - last_fall == 2*exp_n, "R5", cyc - last_fall, 2*exp_n);
        end
        acc = {acc[14:0], sdin};
        nbits++;
        last_fall = cyc;
      end
      if (!p_sync && sync_n) begin
        chk(nbits == 16, fr_idx == 0 ? "R2" : "R3", nbits, 16);
        if (exp_q.size() == 0) chk(0, "R10", acc, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(acc == e, fr_idx == 0 ? "R2" : "R3", acc, e);
        end
        fr_idx++;
        frames_total++;
        sync_rise = cyc;
        if (fr_idx == 2 && cfg_auto) chk(busy == 1'b0, "R9", busy, 0);
        nbits = 0;
      end
      if (p_sync && !sync_n) begin
        if (fr_idx == 1) chk(cyc - sync_rise == exp_gap, "R6", cyc - sync_rise, exp_gap);
        nbits = 0;
      end
      if (in_seq && !cfg_auto && p_ldac && !ldac_n) begin
        chk(sync_n && fr_idx == 2, "R8", fr_idx, 2);
        ldac_fall = cyc;
      end
      if (in_seq && !cfg_auto && !p_ldac && ldac_n) begin
        chk(cyc - ldac_fall == exp_ld, "R8", cyc - ldac_fall, exp_ld);
        chk(busy == 1'b0, "R8", busy, 0);
      end
    end
    p_sclk = sclk;
    p_sync = sync_n;
    p_ldac = ldac_n;
  end

  // driver: programs the setup, pushes expected words, issues the strobe
  task automatic run_seq(input logic [11:0] a, input logic [11:0] b, input int h,
                         input int g, input int l, input bit bm, input bit au,
                         input int spoil_at);
    @(negedge clk);
    half_div = 8'(h); gap_clks = 8'(g); ldac_clks = 8'(l);
    byte_mode = bm; auto_update = au;
    exp_n = (h == 0) ? 1 : h;
    exp_gap = (g > 2*exp_n) ? g : 2*exp_n;
    exp_ld  = (l > 2*exp_n) ? l : 2*exp_n;
    cfg_byte = bm; cfg_auto = au;
    exp_q.push_back({3'b000, 1'b0, a});
    exp_q.push_back({3'b000, 1'b1, b});
    fr_idx = 0;
    repeat (2) @(negedge clk);
    in_seq = 1;
    code_a = a; code_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && sync_n == 1'b0, "R11", busy, 1);
    if (spoil_at > 0) begin
      repeat (spoil_at) @(negedge clk);
      code_a = 12'hFFF; code_b = 12'hFFF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(fr_idx == 2, "R3", fr_idx, 2);
    chk(exp_q.size() == 0, "R3", exp_q.size(), 0);
    if (au) chk(ldac_n == 1'b0, "R9", ldac_n, 0);
    if (spoil_at > 0) chk(sync_n == 1'b1 && busy == 1'b0, "R10", busy, 0);
    in_seq = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: values while reset is held
    chk(sclk == 1'b0 && sync_n == 1'b1, "R1", {sclk, sync_n}, 1);
    chk(ldac_n == 1'b1 && busy == 1'b0, "R1", {ldac_n, busy}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sync_n == 1'b1 && busy == 1'b0 && sclk == 1'b0, "R1", {sync_n, busy, sclk}, 4);
    p_sclk = sclk; p_sync = sync_n; p_ldac = ldac_n;
    mon_on = 1;
    run_seq(12'h7FF, 12'h800, 1, 0, 0, 0, 0, 0);
    run_seq(12'hABC, 12'h123, 3, 20, 9, 0, 0, 0);
    run_seq(12'h001, 12'hFFF, 2, 1, 30, 1, 0, 0);
    run_seq(12'h5A5, 12'h0F0, 0, 3, 0, 0, 1, 0);
    run_seq(12'h3C3, 12'h456, 2, 6, 5, 0, 0, 40);
    run_seq(12'h000, 12'hA5A, 1, 0, 4, 1, 1, 0);
    repeat (20) @(negedge clk);
    chk(frames_total == 12, "R3", frames_total, 12);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule